// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block chooses which of four DMA channels may run its next transfer. Each channel raises a request line. A per-channel enable qualifies that request, and any request whose enable is low is dropped before arbitration. A 2-bit priority-mode input selects how simultaneous requests are ranked. Three settings are fixed orders, one of which lets channel 2 outrank channel 0. The fourth setting is a rotating scheme in which the channel that just finished falls to the bottom of the ranking.

The winner is shown on a one-hot grant with a valid flag. The grant stays on that channel until the channel pulses transfer-done. A global address-error input suspends all granting while it is high. When the error clears, arbitration resumes, and the rotation pointer still holds the value it had before the error.

The control is a three-state machine:
- IDLE waits for a qualified request.
- GRANT holds the winner.
- HALT is entered whenever the error input is high.

The transitions are:
- IDLE→GRANT on a qualified request with no error.
- IDLE→HALT on an error.
- GRANT→IDLE on transfer-done with no error.
- GRANT→HALT on an error, whether or not transfer-done is present.
- HALT→IDLE when the error clears.

In all other cases the machine stays in its current state.

Top module: `dma_chan_arbiter`

## Requirements
- R1: Reset conditions: during and after reset, `grant` is 0000 and `grant_valid` is 0. The registered mode is 00 and the rotation pointer favours channel 0.
- R2: In mode 00, simultaneous qualified requests are ranked channel 0 first, then 1, then 2, then 3. Grant bit i stands for channel i.
- R3: In mode 01, the ranking is channel 0, then 2, then 3, then 1.
- R4: In mode 10, the ranking is channel 2, then 0, then 1, then 3.
- R5: Mode 11 is rotating. When a transfer-done arrives while the registered mode is 11, the channel that finished becomes lowest priority and the channel above it in numeric order (wrapping 3→0) becomes highest. Only transfer-done in mode 11 moves the pointer.
- R6: A single qualified request is granted whatever the mode.
- R7: A request whose `chan_en` bit is 0 is never granted. If no enabled channel requests, `grant_valid` stays 0.
- R8: A grant is held unchanged until `xfer_done` is sampled high. After that, `grant_valid` is 0 for one cycle, and a new arbitration result appears on the following cycle.
- R9: Once `addr_err` is sampled high, `grant_valid` is 0 from the next cycle for as long as `addr_err` stays high. An interrupted grant is dropped.
- R10: After `addr_err` clears, arbitration restarts from the unchanged rotation pointer. A grant appears two cycles after the first clock that samples `addr_err` low.
- R11: `grant` is zero or one-hot, and `grant_valid` is 1 exactly when `grant` is non-zero.
- R12: `prio_mode` is registered. An arbitration decision uses the mode sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 4 | Transfer request per channel |
| chan_en | input | 4 | Enable qualifier per channel |
| prio_mode | input | 2 | 00/01/10 fixed orders, 11 rotating |
| addr_err | input | 1 | Global suspend while high |
| xfer_done | input | 1 | Pulse ending the granted transfer |
| grant | output | 4 | One-hot granted channel |
| grant_valid | output | 1 | A grant is active |

## Verification
When a request is applied in IDLE, the grant is visible after the next rising edge. When transfer-done is sampled, the grant drops one cycle later, and the next grant appears one cycle after that. When the error is sampled, the grant drops after one edge; once the error clears, the next grant appears after two edges. A mode change takes effect one edge later than the request it arrives with. Each stimulus task queues its expected grant together with the cycle number at which it is due. The monitor compares only on the falling edge of that cycle, so every check lands exactly on the cycle given by these latencies.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int NUM_CH = 4;
    localparam int CH_W   = $clog2(NUM_CH);

    typedef logic [CH_W-1:0] ch_idx_t;

    typedef enum logic [1:0] {
        MODE_ASCEND    = 2'b00,
        MODE_SKIP_ONE  = 2'b01,
        MODE_TWO_FIRST = 2'b10,
        MODE_ROTATE    = 2'b11
    } prio_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_HALT  = 2'd2
    } arb_state_e;

    // Channel sitting at rank r (0 = strongest) for each fixed order.
    function automatic ch_idx_t rank_to_chan(prio_mode_e m, int r);
        ch_idx_t c;
        unique case (m)
            MODE_SKIP_ONE:  c = (r == 0) ? ch_idx_t'(0) : (r == 1) ? ch_idx_t'(2) :
                                (r == 2) ? ch_idx_t'(3) : ch_idx_t'(1);
            MODE_TWO_FIRST: c = (r == 0) ? ch_idx_t'(2) : (r == 1) ? ch_idx_t'(0) :
                                (r == 2) ? ch_idx_t'(1) : ch_idx_t'(3);
            default:        c = ch_idx_t'(r);
        endcase
        return c;
    endfunction
endpackage

// File: rtl/arb_req_mask.sv
module arb_req_mask #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] en,
    output logic [N-1:0] eff,
    output logic         any
);
    for (genvar i = 0; i < N; i++) begin : g_mask
        assign eff[i] = req[i] & en[i];
    end
    assign any = |eff;
endmodule

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick
    import arb_pkg::*;
(
    input  logic [NUM_CH-1:0] eff,
    input  prio_mode_e        mode,
    output logic              hit,
    output ch_idx_t           idx
);
    // Walk from weakest to strongest rank; the last match is the winner.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int r = NUM_CH - 1; r >= 0; r--) begin
            if (eff[rank_to_chan(mode, r)]) begin
                hit = 1'b1;
                idx = rank_to_chan(mode, r);
            end
        end
    end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick
    import arb_pkg::*;
(
    input  logic [NUM_CH-1:0] eff,
    input  ch_idx_t           ptr,
    output logic              hit,
    output ch_idx_t           idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (eff[(int'(ptr) + i) % NUM_CH]) begin
                hit = 1'b1;
                idx = ch_idx_t'((int'(ptr) + i) % NUM_CH);
            end
        end
    end
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] chan_en,
    input  logic [1:0]        prio_mode,
    input  logic              addr_err,
    input  logic              xfer_done,
    output logic [NUM_CH-1:0] grant,
    output logic              grant_valid
);
    arb_state_e        state_q, state_d;
    prio_mode_e        mode_q;
    ch_idx_t           win_q, ptr_q;
    logic [NUM_CH-1:0] eff;
    logic              any_req;
    logic              fix_hit, rr_hit;
    ch_idx_t           fix_idx, rr_idx, pick_idx;

    arb_req_mask #(.N(NUM_CH)) u_mask (
        .req (req),
        .en  (chan_en),
        .eff (eff),
        .any (any_req)
    );

    arb_fixed_pick u_fixed (
        .eff  (eff),
        .mode (mode_q),
        .hit  (fix_hit),
        .idx  (fix_idx)
    );

    arb_rr_pick u_rr (
        .eff (eff),
        .ptr (ptr_q),
        .hit (rr_hit),
        .idx (rr_idx)
    );

    assign pick_idx = (mode_q == MODE_ROTATE) ? rr_idx : fix_idx;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (addr_err)     state_d = ST_HALT;
                      else if (any_req) state_d = ST_GRANT;
            ST_GRANT: if (addr_err)     state_d = ST_HALT;
                      else if (xfer_done) state_d = ST_IDLE;
            ST_HALT:  if (!addr_err)    state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Mode, winner and rotation pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_ASCEND;
            win_q  <= '0;
            ptr_q  <= '0;
        end else begin
            mode_q <= prio_mode_e'(prio_mode);
            if (state_q == ST_IDLE && state_d == ST_GRANT)
                win_q <= pick_idx;
            if (state_q == ST_GRANT && xfer_done && mode_q == MODE_ROTATE)
                ptr_q <= (int'(win_q) == NUM_CH - 1) ? ch_idx_t'(0) : ch_idx_t'(win_q + 1'b1);
        end
    end

    // Outputs
    always_comb begin
        grant       = '0;
        grant_valid = 1'b0;
        unique case (state_q)
            ST_GRANT: begin
                grant[win_q] = 1'b1;
                grant_valid  = 1'b1;
            end
            ST_IDLE, ST_HALT: ;
            default: ;
        endcase
    end

    AST_GRANT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (grant_valid == (grant != '0)));                    // R11
    AST_SUSPEND_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> !grant_valid);                                          // R9
    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !xfer_done && !addr_err |=> grant_valid && $stable(grant)); // R8
    AST_MASKED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> (grant & $past(req & chan_en)) != '0);        // R7
    AST_LONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE && !addr_err && $countones(req & chan_en) == 1
        |=> grant == $past(req & chan_en));                                  // R6
    AST_CH2_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE && !addr_err && mode_q == MODE_TWO_FIRST && req[2] && chan_en[2]
        |=> grant[2]);                                                       // R4
endmodule

// File: tb/tb_dma_chan_arbiter.sv
module tb_dma_chan_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0, chan_en = '0;
    logic [1:0] prio_mode = '0;
    logic       addr_err = 1'b0, xfer_done = 1'b0;
    logic [3:0] grant;
    logic       grant_valid;

    int checks = 0, errors = 0, cyc = 0;
    bit done_run = 1'b0;

    typedef struct {
        int         due;
        logic [3:0] g;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    dma_chan_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req(req), .chan_en(chan_en),
        .prio_mode(prio_mode), .addr_err(addr_err), .xfer_done(xfer_done),
        .grant(grant), .grant_valid(grant_valid)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_in(int dly, logic [3:0] g, string tag);
        exp_t e;
        e.due = cyc + dly; e.g = g; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares every due item on the falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (grant !== e.g || grant_valid !== (e.g != 0)) begin
                errors++;
                $display("FAIL %s grant=%b valid=%b expected grant=%b valid=%b",
                         e.tag, grant, grant_valid, e.g, e.g != 0);
            end
        end
    end

    // Drives one fixed request pattern from IDLE and finishes it.
    task automatic one_shot(logic [1:0] m, logic [3:0] r, logic [3:0] en,
                            logic [3:0] g, string tag);
        prio_mode = m; chan_en = en; req = '0;
        tick(); tick();
        req = r;
        expect_in(1, g, tag);
        tick();
        xfer_done = 1'b1; req = '0;
        tick();
        xfer_done = 1'b0;
        tick();
    endtask

    task automatic finish_xfer(logic [3:0] next_g, string tag);
        xfer_done = 1'b1;
        expect_in(1, 4'b0000, tag);
        expect_in(2, next_g, tag);
        tick();
        xfer_done = 1'b0;
        tick();
    endtask

    initial begin
        tick();
        checks++;
        if (grant !== 4'b0000 || grant_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset grant=%b valid=%b expected 0000/0", grant, grant_valid);
        end
        tick();
        rst_n = 1'b1;
        expect_in(1, 4'b0000, "R1 idle after reset");
        tick(); tick();

        // Rotating mode first, so the pointer still starts at channel 0.
        prio_mode = 2'b11; chan_en = 4'hF;
        tick(); tick();
        req = 4'hF;
        expect_in(1, 4'b0001, "R5 rotate start ch0");
        tick();
        req = 4'b0001;
        expect_in(1, 4'b0001, "R8 held despite request change");
        tick();
        req = 4'hF;
        finish_xfer(4'b0010, "R5 rotate to ch1");
        // Error during grant: dropped, pointer kept.
        addr_err = 1'b1;
        expect_in(1, 4'b0000, "R9 suspend");
        expect_in(3, 4'b0000, "R9 still suspended");
        tick(); tick(); tick();
        addr_err = 1'b0;
        expect_in(2, 4'b0010, "R10 resume from pointer");
        tick(); tick();
        finish_xfer(4'b0100, "R5 rotate to ch2");
        finish_xfer(4'b1000, "R5 rotate to ch3");
        finish_xfer(4'b0001, "R5 rotate wraps to ch0");
        req = 4'b0000;
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        tick();

        one_shot(2'b00, 4'b1110, 4'hF, 4'b0010, "R2 mode00 ch1 over ch2,3");
        one_shot(2'b00, 4'b1100, 4'hF, 4'b0100, "R2 mode00 ch2 over ch3");
        one_shot(2'b01, 4'b1010, 4'hF, 4'b1000, "R3 mode01 ch3 over ch1");
        one_shot(2'b01, 4'b1111, 4'hF, 4'b0001, "R3 mode01 ch0 top");
        one_shot(2'b10, 4'b0101, 4'hF, 4'b0100, "R4 mode10 ch2 over ch0");
        one_shot(2'b10, 4'b1010, 4'hF, 4'b0010, "R4 mode10 ch1 over ch3");
        one_shot(2'b10, 4'b1000, 4'hF, 4'b1000, "R6 lone ch3");
        one_shot(2'b00, 4'b0011, 4'b1110, 4'b0010, "R7 disabled ch0 masked");
        one_shot(2'b00, 4'b0100, 4'b1011, 4'b0000, "R7 only disabled request");

        // Mode change arrives with the request: old mode 00 decides.
        prio_mode = 2'b00; chan_en = 4'hF; req = '0;
        tick(); tick();
        prio_mode = 2'b10; req = 4'b0101;
        expect_in(1, 4'b0001, "R12 old mode used");
        tick();
        finish_xfer(4'b0100, "R12 new mode 10 used");
        req = '0;
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;

        // Error sampled in IDLE blocks the request.
        addr_err = 1'b1; req = 4'b0010;
        expect_in(1, 4'b0000, "R9 error in idle");
        tick(); tick();
        addr_err = 1'b0;
        expect_in(2, 4'b0010, "R10 grant after error clears");
        tick(); tick(); tick();

        while (sb.size() > 0) tick();
        done_run = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_run) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule